// File: doc/BRIEF.md
# DSL Link Activation Controller

This block sequences one end of a point-to-point DSL link through bring-up, steady operation and tear-down. The same machine serves either end. The end strapped as master starts only on a request from the host. The end strapped as slave starts only when it hears line energy, so only the master can open the link. The host picks, per strap, whether the request and quiet controls come from pins or from register bits. Pin requests are edge-detected. Bit requests are sampled as a level.

Activation walks four sub-states in a fixed order, under an activation timeout. Once the link is up, the block watches for loss of line energy. In framed modes it also watches for loss of the frame sync word. Loss persisting for a host-set number of cycles parks the block in a hold sub-state of pending deactivation. From there it either recovers or drains back to inactive. Quiet forces an orderly drain from any busy state. The analog front end, equalizer training and register access are outside the block and appear only as flags.

Top module: `dsl_link_act_ctrl`

## Requirements
- R1: After reset `state_o` is 0 (inactive), and `tx_en`, `link_up` and `act_fail` are 0. The block stays inactive until a valid start condition occurs.
- R2: With `sw_mode`=0 and `is_master`=1, activation starts only on a 0-to-1 change of `req_pin` seen while `quiet_pin` is 0. A pin held high does not restart the block. `req_bit` and `quiet_bit` are ignored.
- R3: With `sw_mode`=1 and `is_master`=1, activation starts in any inactive cycle where `req_bit`=1 and `quiet_bit`=0. `req_pin` and `quiet_pin` are ignored.
- R4: With `is_master`=0, the request inputs are ignored. Activation starts when `energy_det`=1 and the selected quiet control is 0.
- R5: Activation passes through these codes in order:
  - 1 (transmit start, exactly one cycle);
  - 2 (wait for remote, left when `energy_det`=1);
  - 3 (wait for sync, left when sync is qualified);
  - 4 (done, one cycle);
  - 5 (active).
- R6: `frame_mode` 6 or 7 is framed. In framed modes, sync and continued operation need both `energy_det` and `fsw_det`. Every other code ignores `fsw_det`.
- R7: If codes 1 to 3 together last ACT_TIMEOUT+1 cycles without sync, the block returns to code 0. It raises `act_fail` for exactly that one cycle.
- R8: In code 5, `loss_limit` consecutive loss cycles move the block to code 6 (pending hold). A good cycle restarts the count. A `loss_limit` of 0 acts as 1.
- R9: In code 6, a good cycle returns the block to code 5 at the next edge. Otherwise, after PD_TIMEOUT+1 cycles in code 6, it moves to code 7 (drain).
- R10: Quiet seen in codes 1 to 6 moves the block to code 7 at the next edge. Code 7 lasts DRAIN_CYC+1 cycles and then returns to code 0.
- R11: `tx_en` is 1 in every code except 0 and 7. `link_up` is 1 only in code 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| is_master | input | 1 | 1 selects master end, 0 slave end |
| sw_mode | input | 1 | 1 takes request/quiet from bits, 0 from pins |
| req_pin | input | 1 | Activation request pin (edge-sensed) |
| req_bit | input | 1 | Activation request bit (level-sensed) |
| quiet_pin | input | 1 | Quiet pin |
| quiet_bit | input | 1 | Quiet bit |
| energy_det | input | 1 | Line signal energy present |
| fsw_det | input | 1 | Frame sync word detected |
| frame_mode | input | 3 | Framing mode code; 6 and 7 are framed |
| loss_limit | input | LOSS_W | Consecutive loss cycles before pending hold |
| state_o | output | 3 | Current state code (0 to 7) |
| tx_en | output | 1 | Transmitter enable |
| link_up | output | 1 | Link operational |
| act_fail | output | 1 | One-cycle activation timeout pulse |

## Verification
The bench checks the cases below, and what a wrong design would do in each:

- **Held request pin in hardware mode.** A level-sensed design would restart the link over and over after a drain.
- **Request edge that arrives during quiet.** A design that remembers the edge would start once quiet drops.
- **Slave given request inputs.** A slave that obeys them could open the link on its own.
- **Frame sync word in framed and unframed modes.** A wrong mode decode would either stall in wait-for-sync or drop a good unframed link.
- **Exact durations.** The bench counts the cycles of the activation timeout, the pending hold and the drain. It also checks that a broken loss run restarts the count and that a limit of zero acts as one. Off-by-one timers and sticky counters show up as a wrong cycle count or an early deactivation.

// File: rtl/dsl_link_act_ctrl.sv
module dsl_link_act_ctrl #(
  parameter int TMR_W       = 8,
  parameter int ACT_TIMEOUT = 20,
  parameter int PD_TIMEOUT  = 10,
  parameter int DRAIN_CYC   = 3,
  parameter int LOSS_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_master,
  input  logic              sw_mode,
  input  logic              req_pin,
  input  logic              req_bit,
  input  logic              quiet_pin,
  input  logic              quiet_bit,
  input  logic              energy_det,
  input  logic              fsw_det,
  input  logic [2:0]        frame_mode,
  input  logic [LOSS_W-1:0] loss_limit,
  output logic [2:0]        state_o,
  output logic              tx_en,
  output logic              link_up,
  output logic              act_fail
);
  localparam logic [2:0] S_IDLE  = 3'd0;
  localparam logic [2:0] S_TXST  = 3'd1;
  localparam logic [2:0] S_WREM  = 3'd2;
  localparam logic [2:0] S_WSYN  = 3'd3;
  localparam logic [2:0] S_DONE  = 3'd4;
  localparam logic [2:0] S_UP    = 3'd5;
  localparam logic [2:0] S_HOLD  = 3'd6;
  localparam logic [2:0] S_DRAIN = 3'd7;

  localparam logic [TMR_W-1:0]  ACT_LOAD   = TMR_W'(ACT_TIMEOUT);
  localparam logic [TMR_W-1:0]  PD_LOAD    = TMR_W'(PD_TIMEOUT);
  localparam logic [TMR_W-1:0]  DRAIN_LOAD = TMR_W'(DRAIN_CYC);
  localparam logic [TMR_W-1:0]  TMR_ONE    = TMR_W'(1);
  localparam logic [LOSS_W-1:0] LOSS_ONE   = LOSS_W'(1);

  logic [2:0]        st, st_nx;
  logic [TMR_W-1:0]  tmr, tmr_nx;
  logic [LOSS_W-1:0] loss_cnt, loss_nx;
  logic              req_q, fail_nx;

  wire framed  = (frame_mode == 3'd6) || (frame_mode == 3'd7);
  wire quiet   = sw_mode ? quiet_bit : quiet_pin;
  wire req_go  = sw_mode ? req_bit : (req_pin & ~req_q);
  wire start   = ~quiet & (is_master ? req_go : energy_det);
  wire sync_ok = energy_det & (~framed | fsw_det);
  wire tmr_end = (tmr == '0);

  wire [LOSS_W-1:0] lim      = (loss_limit == '0) ? LOSS_ONE : loss_limit;
  wire [LOSS_W:0]   loss_inc = {1'b0, loss_cnt} + {1'b0, LOSS_ONE};
  wire              loss_hit = loss_inc >= {1'b0, lim};

  always_comb begin
    st_nx   = st;
    tmr_nx  = tmr;
    loss_nx = loss_cnt;
    fail_nx = 1'b0;
    case (st)
      S_IDLE: begin
        if (start) begin
          st_nx  = S_TXST;
          tmr_nx = ACT_LOAD;
        end
      end
      S_TXST, S_WREM, S_WSYN: begin
        if (quiet) begin
          st_nx  = S_DRAIN;
          tmr_nx = DRAIN_LOAD;
        end else if (tmr_end) begin
          st_nx   = S_IDLE;
          fail_nx = 1'b1;
        end else begin
          tmr_nx = tmr - TMR_ONE;
          if (st == S_TXST)
            st_nx = S_WREM;
          else if (st == S_WREM && energy_det)
            st_nx = S_WSYN;
          else if (st == S_WSYN && sync_ok)
            st_nx = S_DONE;
        end
      end
      S_DONE: begin
        if (quiet) begin
          st_nx  = S_DRAIN;
          tmr_nx = DRAIN_LOAD;
        end else begin
          st_nx   = S_UP;
          loss_nx = '0;
        end
      end
      S_UP: begin
        if (quiet) begin
          st_nx  = S_DRAIN;
          tmr_nx = DRAIN_LOAD;
        end else if (!sync_ok) begin
          if (loss_hit) begin
            st_nx   = S_HOLD;
            tmr_nx  = PD_LOAD;
            loss_nx = '0;
          end else begin
            loss_nx = loss_inc[LOSS_W-1:0];
          end
        end else begin
          loss_nx = '0;
        end
      end
      S_HOLD: begin
        if (quiet) begin
          st_nx  = S_DRAIN;
          tmr_nx = DRAIN_LOAD;
        end else if (sync_ok) begin
          st_nx   = S_UP;
          loss_nx = '0;
        end else if (tmr_end) begin
          st_nx  = S_DRAIN;
          tmr_nx = DRAIN_LOAD;
        end else begin
          tmr_nx = tmr - TMR_ONE;
        end
      end
      S_DRAIN: begin
        if (tmr_end)
          st_nx = S_IDLE;
        else
          tmr_nx = tmr - TMR_ONE;
      end
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      tmr      <= '0;
      loss_cnt <= '0;
      req_q    <= 1'b1;
      act_fail <= 1'b0;
    end else begin
      st       <= st_nx;
      tmr      <= tmr_nx;
      loss_cnt <= loss_nx;
      req_q    <= req_pin;
      act_fail <= fail_nx;
    end
  end

  assign state_o = st;
  assign tx_en   = (st != S_IDLE) && (st != S_DRAIN);
  assign link_up = (st == S_UP);
endmodule

// File: rtl/dsl_link_act_chk.sv
module dsl_link_act_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       is_master,
  input logic       sw_mode,
  input logic       quiet_pin,
  input logic       quiet_bit,
  input logic       energy_det,
  input logic [2:0] state_o,
  input logic       tx_en,
  input logic       link_up,
  input logic       act_fail
);
  wire q_eff = sw_mode ? quiet_bit : quiet_pin;
  wire busy  = (state_o != 3'd0) && (state_o != 3'd7);

  assert_slave_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_master && state_o == 3'd0 && !energy_det) |=> state_o == 3'd0);

  assert_up_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd5 && $past(state_o) != 3'd5) |->
      ($past(state_o) == 3'd4 || $past(state_o) == 3'd6));

  assert_fail_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    act_fail |=> !act_fail);

  assert_fail_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    act_fail |-> state_o == 3'd0);

  assert_quiet_drain_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (q_eff && busy) |=> state_o == 3'd7);

  assert_drain_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 3'd7 |=> (state_o == 3'd7 || state_o == 3'd0));

  assert_link_tx_R11: assert property (@(posedge clk) disable iff (!rst_n)
    link_up |-> tx_en);
endmodule

bind dsl_link_act_ctrl dsl_link_act_chk i_chk (
  .clk(clk), .rst_n(rst_n), .is_master(is_master), .sw_mode(sw_mode),
  .quiet_pin(quiet_pin), .quiet_bit(quiet_bit), .energy_det(energy_det),
  .state_o(state_o), .tx_en(tx_en), .link_up(link_up), .act_fail(act_fail)
);

// File: tb/test_dsl_link_act_ctrl.sv
module test_dsl_link_act_ctrl;
  localparam int T_ACT = 20;
  localparam int T_PD  = 10;
  localparam int T_DR  = 3;
  localparam int LW    = 4;

  logic clk = 1'b0;
  logic rst_n, is_master, sw_mode, req_pin, req_bit, quiet_pin, quiet_bit;
  logic energy_det, fsw_det;
  logic [2:0] frame_mode;
  logic [LW-1:0] loss_limit;
  logic [2:0] state_o;
  logic tx_en, link_up, act_fail;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dsl_link_act_ctrl #(.ACT_TIMEOUT(T_ACT), .PD_TIMEOUT(T_PD),
                      .DRAIN_CYC(T_DR), .LOSS_W(LW)) i_dsl_link_act_ctrl (
    .clk(clk), .rst_n(rst_n), .is_master(is_master), .sw_mode(sw_mode),
    .req_pin(req_pin), .req_bit(req_bit), .quiet_pin(quiet_pin),
    .quiet_bit(quiet_bit), .energy_det(energy_det), .fsw_det(fsw_det),
    .frame_mode(frame_mode), .loss_limit(loss_limit), .state_o(state_o),
    .tx_en(tx_en), .link_up(link_up), .act_fail(act_fail));

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; is_master = 1'b1; sw_mode = 1'b0;
    req_pin = 1'b0; req_bit = 1'b0; quiet_pin = 1'b0; quiet_bit = 1'b0;
    energy_det = 1'b0; fsw_det = 1'b0; frame_mode = 3'd0; loss_limit = 4'd3;
    repeat (3) step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic activate_sw(input logic [2:0] mode);
    sw_mode = 1'b1; is_master = 1'b1; frame_mode = mode;
    energy_det = 1'b1; fsw_det = 1'b1; req_bit = 1'b1;
    step();
    req_bit = 1'b0;
    repeat (4) step();
    chk("R5 reach active", state_o, 5);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 state", state_o, 0);
    chk("R1 tx_en", tx_en, 0);
    chk("R1 link_up", link_up, 0);
    chk("R1 act_fail", act_fail, 0);
    req_bit = 1'b1;
    repeat (5) step();
    chk("R1 R2 stays idle, bit ignored in hw", state_o, 0);
    req_bit = 1'b0;
  endtask

  task automatic t_hw_master();
    do_reset();
    quiet_pin = 1'b1; req_pin = 1'b1;
    repeat (2) step();
    chk("R2 edge under quiet", state_o, 0);
    quiet_pin = 1'b0;
    repeat (3) step();
    chk("R2 no edge after quiet drop", state_o, 0);
    req_pin = 1'b0; step();
    req_pin = 1'b1; step();
    chk("R2 edge starts", state_o, 1);
    chk("R11 tx_en in txstart", tx_en, 1);
    step();
    chk("R5 wait remote", state_o, 2);
    step();
    chk("R5 hold wait remote", state_o, 2);
    energy_det = 1'b1; step();
    chk("R5 wait sync", state_o, 3);
    step();
    chk("R5 done", state_o, 4);
    step();
    chk("R5 active", state_o, 5);
    chk("R11 link_up", link_up, 1);
    quiet_pin = 1'b1; step();
    chk("R10 quiet from active", state_o, 7);
    chk("R11 tx_en off in drain", tx_en, 0);
    quiet_pin = 1'b0;
    repeat (T_DR) step();
    chk("R10 drain length", state_o, 7);
    step();
    chk("R10 drain exit", state_o, 0);
    repeat (3) step();
    chk("R2 held pin no restart", state_o, 0);
    req_pin = 1'b0; step();
    req_pin = 1'b1; step();
    chk("R2 second edge", state_o, 1);
    quiet_pin = 1'b1; step();
    chk("R10 quiet in txstart", state_o, 7);
    repeat (T_DR + 1) step();
    chk("R10 back idle", state_o, 0);
  endtask

  task automatic t_sw_timeout();
    int n;
    do_reset();
    sw_mode = 1'b1;
    req_pin = 1'b1; repeat (2) step();
    chk("R3 pin ignored in sw", state_o, 0);
    quiet_bit = 1'b1; req_bit = 1'b1; repeat (2) step();
    chk("R3 quiet bit blocks", state_o, 0);
    quiet_pin = 1'b1; quiet_bit = 1'b0; step();
    chk("R3 level start, quiet pin ignored", state_o, 1);
    req_bit = 1'b0; quiet_pin = 1'b0;
    n = 1;
    for (int i = 0; i < 100 && state_o != 3'd0; i++) begin
      step();
      if (state_o != 3'd0) n++;
    end
    chk("R7 activating cycles", n, T_ACT + 1);
    chk("R7 fail pulse", act_fail, 1);
    step();
    chk("R7 pulse one cycle", act_fail, 0);
    chk("R7 idle after fail", state_o, 0);
  endtask

  task automatic t_slave();
    do_reset();
    is_master = 1'b0;
    req_pin = 1'b1; repeat (2) step();
    chk("R4 slave ignores pin", state_o, 0);
    sw_mode = 1'b1; req_bit = 1'b1; repeat (2) step();
    chk("R4 slave ignores bit", state_o, 0);
    energy_det = 1'b1; step();
    chk("R4 energy starts slave", state_o, 1);
    step(); chk("R5 slave wait remote", state_o, 2);
    step(); chk("R5 slave wait sync", state_o, 3);
    step(); chk("R5 slave done", state_o, 4);
    step(); chk("R5 slave active", state_o, 5);
  endtask

  task automatic t_framed();
    do_reset();
    sw_mode = 1'b1; frame_mode = 3'd6; energy_det = 1'b1; fsw_det = 1'b0;
    req_bit = 1'b1; step();
    req_bit = 1'b0; repeat (5) step();
    chk("R6 framed waits for sync word", state_o, 3);
    fsw_det = 1'b1; step();
    chk("R6 sync word qualifies", state_o, 4);
    step();
    chk("R6 active", state_o, 5);
    loss_limit = 4'd3; fsw_det = 1'b0;
    repeat (2) step();
    chk("R8 below limit", state_o, 5);
    step();
    chk("R6 R8 sync word loss to hold", state_o, 6);
    chk("R11 tx_en in hold", tx_en, 1);
    chk("R11 link_up off in hold", link_up, 0);
    fsw_det = 1'b1; step();
    chk("R9 recover", state_o, 5);
    frame_mode = 3'd4; fsw_det = 1'b0;
    repeat (6) step();
    chk("R6 unframed ignores sync word", state_o, 5);
    frame_mode = 3'd7;
    repeat (3) step();
    chk("R6 mode 7 framed", state_o, 6);
  endtask

  task automatic t_loss_pd();
    int n;
    do_reset();
    activate_sw(3'd0);
    loss_limit = 4'd3;
    energy_det = 1'b0; repeat (2) step();
    energy_det = 1'b1; step();
    energy_det = 1'b0; repeat (2) step();
    chk("R8 good cycle restarts count", state_o, 5);
    step();
    chk("R8 limit reached", state_o, 6);
    n = 1;
    for (int i = 0; i < 100 && state_o == 3'd6; i++) begin
      step();
      if (state_o == 3'd6) n++;
    end
    chk("R9 hold cycles", n, T_PD + 1);
    chk("R9 to drain", state_o, 7);
    repeat (T_DR) step();
    chk("R10 drain still", state_o, 7);
    step();
    chk("R10 drain done", state_o, 0);
    do_reset();
    activate_sw(3'd1);
    loss_limit = 4'd0; energy_det = 1'b0; step();
    chk("R8 zero limit acts as one", state_o, 6);
    quiet_bit = 1'b1; step();
    chk("R10 quiet in hold", state_o, 7);
  endtask

  task automatic t_quiet_act();
    do_reset();
    sw_mode = 1'b1; req_bit = 1'b1; step();
    req_bit = 1'b0; step();
    chk("R5 wait remote", state_o, 2);
    quiet_bit = 1'b1; step();
    chk("R10 quiet in wait remote", state_o, 7);
    quiet_bit = 1'b0;
    repeat (T_DR + 1) step();
    chk("R10 idle after drain", state_o, 0);
    chk("R10 no fail pulse", act_fail, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_hw_master();
    t_sw_timeout();
    t_slave();
    t_framed();
    t_loss_pd();
    t_quiet_act();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule